// File: doc/BRIEF.md
# Cascadable configuration memory sequencer

This block is the read side of a configuration store. It streams a fixed bitstream to a downstream programmable device, either one bit per clock on a serial line or one byte per clock on a parallel bus. An address counter and a bit counter walk the stored bytes on each rising clock edge while the block is selected. When the last stored item has been shown, the block leaves the bus and drops its chain-out strobe. That strobe can enable the next identical instance, so several instances that share one clock and one data line give one continuous stream.

The stored content is a small computed pattern. Byte `a` holds `(a * PAT_STEP + PAT_BASE) mod 256`. The tristate behaviour is modelled as separate data and enable outputs. The surrounding logic resolves the wired line.

Top module: `cfg_stream_mem`

## Requirements
- R1: With `par_mode_i` = 0 (serial, the default), `ser_o` shows one stored bit per clock, starting at bit 7 of byte 0, most significant bit first, then byte 1 and so on.
- R2: With `par_mode_i` = 1, `par_o` shows one whole stored byte per clock, starting at byte 0 and advancing one address per clock.
- R3: While data is being delivered, only the enable of the selected output is high: `ser_oe_o` in serial mode, `par_oe_o` in parallel mode.
- R4: The last item is bit index `MEM_BYTES*8-1` in serial mode, or byte `MEM_BYTES-1` in parallel mode. On the clock edge after that item has been shown, `cas_no` goes low and both output enables go low.
- R5: Once `cas_no` is low, it stays low, the output enables stay low and the counters do not move until `ce_ni` goes high or `rst_ni` goes low.
- R6: While `ce_ni` is high, both output enables are low and `cas_no` is high. A clock edge with `ce_ni` high returns the counters to zero, so the next selection restarts at item 0.
- R7: `rst_ni` low clears the counters at once. While `rst_ni` is low, the outputs are in the same idle state as in R6.
- R8: Two instances chained through `cas_no` into `ce_ni`, on a shared clock, deliver the first instance's content and then the second instance's content with no gap. The two instances never enable outputs at the same time.
- R9: Stored byte `a` equals `(a*PAT_STEP + PAT_BASE) mod 256`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Read clock supplied by the device being configured |
| rst_ni | input | 1 | Asynchronous active-low reset / output disable |
| ce_ni | input | 1 | Active-low chip enable |
| par_mode_i | input | 1 | Output mode: 0 serial, 1 byte-wide |
| ser_o | output | 1 | Serial data bit |
| ser_oe_o | output | 1 | Drive enable for `ser_o` |
| par_o | output | 8 | Parallel data byte |
| par_oe_o | output | 1 | Drive enable for `par_o` |
| cas_no | output | 1 | Active-low chain-out enable for the next instance |

## Verification
A bit counter that is off by one shows up as a wrong bit on the shared line in the very cycle of the error. It also shifts the handoff by one clock, so the second instance's first item appears early or late. An address counter that is not cleared on deselect or reset shows up at the first item after reselection, because the first bit or byte differs from byte 0. A done flag that does not hold shows up within one clock after the handoff. In that case the first instance re-enables its output while the second one is driving, and the bench flags that as a driver overlap.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT_IW = 3;

  typedef enum logic {
    MODE_SER = 1'b0,
    MODE_PAR = 1'b1
  } out_mode_e;

  function automatic logic [BYTE_W-1:0] pat_byte(int unsigned a, int unsigned step,
                                                 int unsigned base);
    int unsigned v;
    v = (a * step + base) % 256;
    return v[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/cfg_rom.sv
module cfg_rom
  import cfg_stream_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 16,
  parameter int unsigned PAT_STEP  = 37,
  parameter int unsigned PAT_BASE  = 5,
  localparam int unsigned AW = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1
) (
  input  logic [AW-1:0]     addr_i,
  output logic [BYTE_W-1:0] data_o
);
  logic [BYTE_W-1:0] rom [MEM_BYTES];

  for (genvar g = 0; g < MEM_BYTES; g++) begin : g_word
    assign rom[g] = pat_byte(g, PAT_STEP, PAT_BASE);
  end

  always_comb begin
    data_o = '0;
    if (int'(addr_i) < MEM_BYTES) data_o = rom[addr_i];
  end
endmodule

// File: rtl/cfg_addr_ctr.sv
module cfg_addr_ctr
  import cfg_stream_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 16,
  localparam int unsigned AW = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1,
  localparam logic [AW-1:0] LAST_ADDR = AW'(MEM_BYTES - 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  out_mode_e         mode_i,
  output logic [AW-1:0]     addr_o,
  output logic [BIT_IW-1:0] bit_o,
  output logic              done_o
);
  logic [AW-1:0]     addr_q;
  logic [BIT_IW-1:0] bit_q;
  logic              done_q;
  logic              at_last;

  always_comb begin
    if (mode_i == MODE_PAR) at_last = (addr_q == LAST_ADDR);
    else                    at_last = (addr_q == LAST_ADDR) && (bit_q == 3'd7);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else if (!en_i) begin
      addr_q <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (at_last) begin
        done_q <= 1'b1;
      end else if (mode_i == MODE_PAR) begin
        addr_q <= addr_q + AW'(1);
      end else if (bit_q == 3'd7) begin
        bit_q  <= '0;
        addr_q <= addr_q + AW'(1);
      end else begin
        bit_q <= bit_q + 3'd1;
      end
    end
  end

  assign addr_o = addr_q;
  assign bit_o  = bit_q;
  assign done_o = done_q;

  assert_addr_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_q <= LAST_ADDR);

  assert_done_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && en_i) |=> (done_q && $stable(addr_q) && $stable(bit_q)));

  assert_deselect_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (addr_q == '0 && bit_q == '0 && !done_q));

  assert_par_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !done_q && mode_i == MODE_PAR && addr_q != LAST_ADDR)
      |=> (addr_q == $past(addr_q) + AW'(1)));
endmodule

// File: rtl/cfg_out_drv.sv
module cfg_out_drv
  import cfg_stream_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              done_i,
  input  out_mode_e         mode_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [BIT_IW-1:0] bit_i,
  output logic              ser_o,
  output logic              ser_oe_o,
  output logic [BYTE_W-1:0] par_o,
  output logic              par_oe_o,
  output logic              cas_no
);
  logic live;

  assign live     = en_i && !done_i;
  assign ser_oe_o = live && (mode_i == MODE_SER);
  assign par_oe_o = live && (mode_i == MODE_PAR);
  assign ser_o    = ser_oe_o ? byte_i[3'd7 - bit_i] : 1'b0;
  assign par_o    = par_oe_o ? byte_i : '0;
  assign cas_no   = !(en_i && done_i);

  assert_single_oe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ser_oe_o, par_oe_o}));

  assert_idle_when_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (cas_no && !ser_oe_o && !par_oe_o));

  assert_handoff_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_no |-> (!ser_oe_o && !par_oe_o));
endmodule

// File: rtl/cfg_stream_mem.sv
module cfg_stream_mem
  import cfg_stream_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 16,
  parameter int unsigned PAT_STEP  = 37,
  parameter int unsigned PAT_BASE  = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce_ni,
  input  logic       par_mode_i,
  output logic       ser_o,
  output logic       ser_oe_o,
  output logic [7:0] par_o,
  output logic       par_oe_o,
  output logic       cas_no
);
  localparam int unsigned AW = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1;

  logic              en;
  out_mode_e         mode;
  logic [AW-1:0]     addr;
  logic [BIT_IW-1:0] bit_idx;
  logic              done;
  logic [BYTE_W-1:0] rd_byte;

  assign en   = !ce_ni && rst_ni;
  assign mode = out_mode_e'(par_mode_i);

  cfg_addr_ctr #(.MEM_BYTES(MEM_BYTES)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .mode_i (mode),
    .addr_o (addr),
    .bit_o  (bit_idx),
    .done_o (done)
  );

  cfg_rom #(.MEM_BYTES(MEM_BYTES), .PAT_STEP(PAT_STEP), .PAT_BASE(PAT_BASE)) u_rom (
    .addr_i (addr),
    .data_o (rd_byte)
  );

  cfg_out_drv u_drv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .done_i   (done),
    .mode_i   (mode),
    .byte_i   (rd_byte),
    .bit_i    (bit_idx),
    .ser_o    (ser_o),
    .ser_oe_o (ser_oe_o),
    .par_o    (par_o),
    .par_oe_o (par_oe_o),
    .cas_no   (cas_no)
  );
endmodule

// File: tb/cfg_stream_mem_bench.sv
`timescale 1ns/1ps
module cfg_stream_mem_bench;
  localparam int unsigned B0 = 4, S0 = 37, P0 = 5;
  localparam int unsigned B1 = 3, S1 = 11, P1 = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1;
  logic pmode = 1'b0;
  logic s0, soe0, poe0, cas0, s1, soe1, poe1, cas1;
  logic [7:0] p0, p1;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  cfg_stream_mem #(.MEM_BYTES(B0), .PAT_STEP(S0), .PAT_BASE(P0)) u_cfg_stream_mem (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .par_mode_i(pmode),
    .ser_o(s0), .ser_oe_o(soe0), .par_o(p0), .par_oe_o(poe0), .cas_no(cas0));

  cfg_stream_mem #(.MEM_BYTES(B1), .PAT_STEP(S1), .PAT_BASE(P1)) u_cfg_stream_mem_nxt (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(cas0), .par_mode_i(pmode),
    .ser_o(s1), .ser_oe_o(soe1), .par_o(p1), .par_oe_o(poe1), .cas_no(cas1));

  // wired shared lines
  logic       ser_bus;
  logic [7:0] par_bus;
  assign ser_bus = soe0 ? s0 : (soe1 ? s1 : 1'bz);
  assign par_bus = poe0 ? p0 : (poe1 ? p1 : 8'hzz);

  function automatic logic [7:0] pat(int unsigned a, int unsigned st, int unsigned bs);
    return 8'((a * st + bs) % 256);
  endfunction

  function automatic int unsigned n_items(int unsigned bytes, logic par);
    return par ? bytes : bytes * 8;
  endfunction

  function automatic logic [7:0] exp_item(int unsigned k, logic par);
    int unsigned t0 = n_items(B0, par);
    logic [7:0] b;
    if (k < t0) b = par ? pat(k, S0, P0) : pat(k / 8, S0, P0);
    else        b = par ? pat(k - t0, S1, P1) : pat((k - t0) / 8, S1, P1);
    if (par) return b;
    if (k < t0) return {7'd0, b[7 - (k % 8)]};
    return {7'd0, b[7 - ((k - t0) % 8)]};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle(string req);
    chk(!soe0 && !poe0 && !soe1 && !poe1 && cas0 && cas1, req,
        {26'd0, soe0, poe0, soe1, poe1, cas0, cas1}, 32'h3);
  endtask

  // abort_kind: 0 none, 1 chip-enable high, 2 reset low
  task automatic run(logic par, int abort_at, int abort_kind);
    int unsigned total = n_items(B0, par) + n_items(B1, par);
    bit aborted = 0;
    @(negedge clk);
    pmode = par;
    @(negedge clk);
    ce_n = 1'b0;
    for (int k = 0; k < int'(total); k++) begin
      #1;
      if (abort_kind != 0 && k == abort_at) begin
        if (abort_kind == 1) ce_n = 1'b1; else rst_n = 1'b0;
        #1;
        if (abort_kind == 1) chk_idle("R6 deselect idle");
        else                 chk_idle("R7 reset idle");
        @(negedge clk);
        rst_n = 1'b1;
        ce_n  = 1'b1;
        aborted = 1;
        break;
      end
      if (par) begin
        chk(par_bus === exp_item(k, 1'b1), k == 0 ? "R2 first byte" : "R2/R9 byte stream",
            {24'd0, par_bus}, {24'd0, exp_item(k, 1'b1)});
        chk(!soe0 && !soe1, "R3 serial oe low in parallel mode", {31'd0, soe0 | soe1}, 0);
      end else begin
        chk(ser_bus === exp_item(k, 1'b0)[0], "R1/R9 serial bit stream",
            {31'd0, ser_bus}, {31'd0, exp_item(k, 1'b0)[0]});
        chk(!poe0 && !poe1, "R3 parallel oe low in serial mode", {31'd0, poe0 | poe1}, 0);
      end
      chk(!((soe0 || poe0) && (soe1 || poe1)), "R8 no driver overlap",
          {30'd0, soe0 | poe0, soe1 | poe1}, 32'h0);
      if (k == int'(n_items(B0, par)))
        chk(!cas0, "R4 handoff to next instance", {31'd0, cas0}, 0);
      @(negedge clk);
    end
    if (aborted) begin
      run(par, -1, 0);
      return;
    end
    #1;
    chk(!cas1 && !soe1 && !poe1 && !soe0 && !poe0, "R4 end of chain quiet",
        {27'd0, cas1, soe0, poe0, soe1, poe1}, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(!cas0 && !cas1 && !soe0 && !poe0 && !soe1 && !poe1, "R5 handoff sticky",
          {30'd0, cas0, cas1}, 0);
    end
    @(negedge clk);
    ce_n = 1'b1;
    #1;
    chk_idle("R6 release after chain end");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7301));
    #1;
    chk_idle("R7 outputs idle in reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk_idle("R6 idle with chip enable high");
    chk(pmode == 1'b0 && cas0, "R3 serial default", {31'd0, pmode}, 0);
    run(1'b0, -1, 0);
    run(1'b1, -1, 0);
    run(1'b0, 13, 1);
    run(1'b1, 5, 2);
    run(1'b0, 32, 2);
    for (int r = 0; r < 12; r++) begin
      logic rp = 1'($urandom % 2);
      int   kind = int'($urandom % 3);
      int   at = int'($urandom % n_items(B0 + B1, rp));
      run(rp, at, kind);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule